// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits behind the write strobes of a parallel flash-style bus and turns multi-cycle unlocked command sequences into single-cycle requests for an internal erase engine. A write cycle is formed by chip enable and write enable. The word address is captured when write enable goes low, and the data byte is captured when write enable goes high again. A command takes effect in the clock cycle after the decoder sees write enable return high.

Two six-write sequences start an erase: a whole-array erase, or a sector erase that also reports the sector index taken from the top address bits of its final write. Single writes suspend and resume a running sector erase, and select the read mode (array or status register). While an erase is suspended the decoder narrows the set of commands it accepts. The erase engine reports through `eng_busy` whether it is executing.

Top module: `erase_cmd_decoder`

## Requirements
- R1: The writes AAh at word address 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 10h at any address pulse `req_chip` high for exactly one cycle. This happens only when `eng_busy` is low and no erase is suspended.
- R2: The same first five writes followed by 30h pulse `req_sector` under the same conditions as R1. `req_sector_sel` is loaded with the top SECT_W bits of the address of that final write, and it changes only together with a `req_sector` pulse.
- R3: The address of a write is the value on `bus_addr` in the cycle where `bus_we_n` is first sampled low. The data is the value on `bus_data` in the cycle where `bus_we_n` is first sampled high again.
- R4: A request is high in the cycle right after the clock edge at which `bus_we_n` is first sampled high at the end of the final write. Every request pulse lasts one cycle.
- R5: `rd_status` (1 = status register mode, 0 = array mode) goes to 1 when an erase, suspend or resume is accepted, or on a single write of 70h from idle. It keeps its value through any other write.
- R6: A write that does not match the expected next step returns the sequence to its start with no request and no mode change. Data F0h at any step returns it to its start and clears `rd_status`.
- R7: A single write of B0h from idle, at any address, is accepted only while `eng_busy` is high, the last started erase was a sector erase, and no erase is suspended. It then pulses `req_suspend` and sets `erase_suspended` and `rd_status`. Otherwise it has no effect.
- R8: While `erase_suspended` is 1, only F0h, 70h and D0h have an effect. Complete erase sequences and B0h produce no request.
- R9: A single write of D0h from idle, at any address, pulses `req_resume` and clears `erase_suspended` only when `erase_suspended` is 1. Otherwise it has no effect.
- R10: A write cycle during which `bus_ce_n` is high is ignored, and the sequence keeps its position.
- R11: After reset all request outputs, `req_sector_sel`, `rd_status` and `erase_suspended` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_data | input | 8 | Command data byte |
| eng_busy | input | 1 | Erase engine is executing or idling in suspend |
| req_chip | output | 1 | Whole-array erase request pulse |
| req_sector | output | 1 | Sector erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_sector_sel | output | SECT_W | Sector index of the last sector erase |
| rd_status | output | 1 | Read mode: 1 status register, 0 array |
| erase_suspended | output | 1 | An erase is currently suspended |

## Verification
The assertions assume that write enable drops and rises with chip enable already low, and that each level is held for at least one clock, so that every edge is sampled. They also assume that `eng_busy` is driven only from the bench's engine model. The stimulus builds every write cycle from a single task that holds each phase for one full clock and changes inputs only on the falling clock edge. Chip-enable-high writes and split address/data values are made by the same task, so every cycle keeps the same edge order.

// File: rtl/erase_dec_pkg.sv
`timescale 1ns/1ps
package erase_dec_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_SETUP, SQ_UNL3, SQ_UNL4
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_CHIP, CMD_SECTOR, CMD_SUSPEND,
        CMD_RESUME, CMD_RD_ARRAY, CMD_RD_STATUS
    } cmd_kind_t;

    typedef struct packed {
        logic rd_status;
        logic suspended;
        logic sector_run;
    } mode_t;

    localparam logic [7:0]  CODE_KEY_A     = 8'hAA;
    localparam logic [7:0]  CODE_KEY_B     = 8'h55;
    localparam logic [7:0]  CODE_SETUP     = 8'h80;
    localparam logic [7:0]  CODE_CHIP      = 8'h10;
    localparam logic [7:0]  CODE_SECTOR    = 8'h30;
    localparam logic [7:0]  CODE_SUSPEND   = 8'hB0;
    localparam logic [7:0]  CODE_RESUME    = 8'hD0;
    localparam logic [7:0]  CODE_RD_ARRAY  = 8'hF0;
    localparam logic [7:0]  CODE_RD_STATUS = 8'h70;
    localparam logic [15:0] ADDR_KEY_A     = 16'h5555;
    localparam logic [15:0] ADDR_KEY_B     = 16'h2AAA;

    function automatic logic key_a_hit(input logic [15:0] a, input logic [7:0] d);
        return (a == ADDR_KEY_A) && (d == CODE_KEY_A);
    endfunction

    function automatic logic key_b_hit(input logic [15:0] a, input logic [7:0] d);
        return (a == ADDR_KEY_B) && (d == CODE_KEY_B);
    endfunction

endpackage

// File: rtl/we_edge_capture.sv
`timescale 1ns/1ps
module we_edge_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              we_q;
    logic              armed;
    logic [ADDR_W-1:0] addr_q;
    logic              fall_seen;
    logic              rise_seen;

    assign fall_seen = we_q && !we_n;
    assign rise_seen = !we_q && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q   <= 1'b1;
            armed  <= 1'b0;
            addr_q <= '0;
        end else begin
            we_q <= we_n;
            if (fall_seen && !ce_n) begin
                addr_q <= addr;
                armed  <= 1'b1;
            end else if (rise_seen) begin
                armed <= 1'b0;
            end
        end
    end

    // Data is taken as it stands when write enable returns high.
    assign wr_stb  = armed && rise_seen && !ce_n;
    assign wr_addr = addr_q;
    assign wr_data = data;
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
    import erase_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              locked,
    output cmd_kind_t         cmd,
    output logic [ADDR_W-1:0] cmd_addr
);
    seq_state_t state_q, state_d;
    logic [15:0] alo;

    assign alo      = wr_addr[15:0];
    assign cmd_addr = wr_addr;

    always_comb begin
        state_d = state_q;
        cmd     = CMD_NONE;
        if (wr_stb) begin
            state_d = SQ_IDLE;
            if (wr_data == CODE_RD_ARRAY) begin
                cmd = CMD_RD_ARRAY;
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        if (wr_data == CODE_RD_STATUS)      cmd = CMD_RD_STATUS;
                        else if (wr_data == CODE_RESUME)    cmd = CMD_RESUME;
                        else if (!locked) begin
                            if (wr_data == CODE_SUSPEND)    cmd = CMD_SUSPEND;
                            else if (key_a_hit(alo, wr_data)) state_d = SQ_UNL1;
                        end
                    end
                    SQ_UNL1:  if (key_b_hit(alo, wr_data)) state_d = SQ_UNL2;
                    SQ_UNL2:  if (alo == ADDR_KEY_A && wr_data == CODE_SETUP) state_d = SQ_SETUP;
                    SQ_SETUP: if (key_a_hit(alo, wr_data)) state_d = SQ_UNL3;
                    SQ_UNL3:  if (key_b_hit(alo, wr_data)) state_d = SQ_UNL4;
                    SQ_UNL4: begin
                        if (wr_data == CODE_CHIP)        cmd = CMD_CHIP;
                        else if (wr_data == CODE_SECTOR) cmd = CMD_SECTOR;
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/mode_tracker.sv
`timescale 1ns/1ps
module mode_tracker
    import erase_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_kind_t         cmd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              eng_busy,
    output logic              req_chip,
    output logic              req_sector,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [SECT_W-1:0] sector_sel,
    output logic              rd_status,
    output logic              suspended
);
    localparam int SEL_LSB = ADDR_W - SECT_W;

    mode_t mode_q;
    logic  start_ok;

    assign start_ok = !eng_busy && !mode_q.suspended;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            req_chip    <= 1'b0;
            req_sector  <= 1'b0;
            req_suspend <= 1'b0;
            req_resume  <= 1'b0;
            sector_sel  <= '0;
        end else begin
            req_chip    <= 1'b0;
            req_sector  <= 1'b0;
            req_suspend <= 1'b0;
            req_resume  <= 1'b0;
            unique case (cmd)
                CMD_CHIP: if (start_ok) begin
                    req_chip          <= 1'b1;
                    mode_q.rd_status  <= 1'b1;
                    mode_q.sector_run <= 1'b0;
                end
                CMD_SECTOR: if (start_ok) begin
                    req_sector        <= 1'b1;
                    sector_sel        <= cmd_addr[SEL_LSB +: SECT_W];
                    mode_q.rd_status  <= 1'b1;
                    mode_q.sector_run <= 1'b1;
                end
                CMD_SUSPEND: if (eng_busy && mode_q.sector_run && !mode_q.suspended) begin
                    req_suspend      <= 1'b1;
                    mode_q.suspended <= 1'b1;
                    mode_q.rd_status <= 1'b1;
                end
                CMD_RESUME: if (mode_q.suspended) begin
                    req_resume       <= 1'b1;
                    mode_q.suspended <= 1'b0;
                    mode_q.rd_status <= 1'b1;
                end
                CMD_RD_ARRAY:  mode_q.rd_status <= 1'b0;
                CMD_RD_STATUS: mode_q.rd_status <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rd_status = mode_q.rd_status;
    assign suspended = mode_q.suspended;
endmodule

// File: rtl/erase_cmd_decoder.sv
`timescale 1ns/1ps
module erase_cmd_decoder
    import erase_dec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_data,
    input  logic              eng_busy,
    output logic              req_chip,
    output logic              req_sector,
    output logic              req_suspend,
    output logic              req_resume,
    output logic [SECT_W-1:0] req_sector_sel,
    output logic              rd_status,
    output logic              erase_suspended
);
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    cmd_kind_t         cmd;
    logic [ADDR_W-1:0] cmd_addr;

    we_edge_capture #(.ADDR_W(ADDR_W)) cap_i (
        .clk(clk), .rst(rst), .ce_n(bus_ce_n), .we_n(bus_we_n),
        .addr(bus_addr), .data(bus_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    seq_fsm #(.ADDR_W(ADDR_W)) seq_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(erase_suspended),
        .cmd(cmd), .cmd_addr(cmd_addr)
    );

    mode_tracker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) mode_i (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_addr(cmd_addr),
        .eng_busy(eng_busy),
        .req_chip(req_chip), .req_sector(req_sector),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .sector_sel(req_sector_sel), .rd_status(rd_status),
        .suspended(erase_suspended)
    );
endmodule

// File: rtl/erase_cmd_decoder_chk.sv
`timescale 1ns/1ps
module erase_cmd_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_ce_n,
    input logic              bus_we_n,
    input logic              eng_busy,
    input logic              req_chip,
    input logic              req_sector,
    input logic              req_suspend,
    input logic              req_resume,
    input logic [SECT_W-1:0] req_sector_sel,
    input logic              rd_status,
    input logic              erase_suspended
);
    logic any_req;
    assign any_req = req_chip || req_sector || req_suspend || req_resume;

    a_r1_chip_one_cycle: assert property (@(posedge clk) disable iff (rst)
        req_chip |=> !req_chip);

    a_r2_sel_moves_with_req: assert property (@(posedge clk) disable iff (rst)
        !$stable(req_sector_sel) |-> req_sector);

    a_r4_after_we_rise: assert property (@(posedge clk) disable iff (rst)
        (req_chip || req_sector) |-> ($past(bus_we_n) && !$past(bus_we_n, 2)));

    a_r5_status_on_accept: assert property (@(posedge clk) disable iff (rst)
        any_req |-> rd_status);

    a_r7_suspend_needs_busy: assert property (@(posedge clk) disable iff (rst)
        req_suspend |-> ($past(eng_busy) && !$past(erase_suspended) && erase_suspended));

    a_r8_no_start_when_held: assert property (@(posedge clk) disable iff (rst)
        erase_suspended |-> !(req_chip || req_sector));

    a_r9_resume_clears: assert property (@(posedge clk) disable iff (rst)
        req_resume |-> ($past(erase_suspended) && !erase_suspended));

    a_r10_ce_high_no_req: assert property (@(posedge clk) disable iff (rst)
        $past(bus_ce_n) |-> !any_req);

    a_r11_one_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_chip, req_sector, req_suspend, req_resume}));
endmodule

bind erase_cmd_decoder erase_cmd_decoder_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) chk_i (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .eng_busy(eng_busy), .req_chip(req_chip), .req_sector(req_sector),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .req_sector_sel(req_sector_sel), .rd_status(rd_status),
    .erase_suspended(erase_suspended)
);

// File: tb/erase_cmd_decoder_tb.sv
`timescale 1ns/1ps
module erase_cmd_decoder_tb_top;
    localparam int ADDR_W = 16;
    localparam int SECT_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_ce_n = 1'b1;
    logic              bus_we_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_data = '0;
    logic              eng_busy = 1'b0;
    logic              req_chip, req_sector, req_suspend, req_resume;
    logic [SECT_W-1:0] req_sector_sel;
    logic              rd_status, erase_suspended;

    int checks = 0;
    int errors = 0;
    logic s_chip, s_sector, s_susp, s_res;

    always #4 clk = ~clk;

    erase_cmd_decoder #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) dut_i (
        .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .eng_busy(eng_busy),
        .req_chip(req_chip), .req_sector(req_sector),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .req_sector_sel(req_sector_sel), .rd_status(rd_status),
        .erase_suspended(erase_suspended)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write cycle: address on the low phase, data on the high phase.
    task automatic bus_wr(input logic [15:0] a_lo, input logic [15:0] a_hi,
                          input logic [7:0] d_lo, input logic [7:0] d_hi,
                          input logic ce);
        @(negedge clk);
        bus_ce_n = ce; bus_addr = a_lo; bus_data = d_lo; bus_we_n = 1'b0;
        @(negedge clk);
        bus_addr = a_hi; bus_data = d_hi; bus_we_n = 1'b1;
        @(negedge clk);
        s_chip = req_chip; s_sector = req_sector;
        s_susp = req_suspend; s_res = req_resume;
        bus_ce_n = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_wr(a, a, d, d, 1'b0);
    endtask

    task automatic prefix();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 req", int'({req_chip, req_sector, req_suspend, req_resume}), 0);
        chk("R11 sel", int'(req_sector_sel), 0);
        chk("R11 status", int'(rd_status), 0);
        chk("R11 susp", int'(erase_suspended), 0);

        // R1 chip erase, R4 one cycle pulse
        prefix(); wr(16'h0000, 8'h10);
        chk("R1 chip", int'(s_chip), 1);
        chk("R1 sector", int'(s_sector), 0);
        chk("R5 status after erase", int'(rd_status), 1);
        @(negedge clk);
        chk("R4 pulse width", int'(req_chip), 0);

        // R5 status persists, R6 F0 to array, 70 to status
        wr(16'h0000, 8'h12);
        chk("R5 status kept", int'(rd_status), 1);
        wr(16'h1234, 8'hF0);
        chk("R6 F0 array", int'(rd_status), 0);
        wr(16'h0000, 8'h70);
        chk("R5 70 status", int'(rd_status), 1);

        // R2 sector select sweep
        for (int s = 0; s < 16; s++) begin
            prefix(); wr({s[3:0], 12'h123}, 8'h30);
            chk("R2 sector req", int'(s_sector), 1);
            chk("R2 sector sel", int'(req_sector_sel), s);
        end

        // R1/R2 final code sweep
        for (int c = 0; c < 256; c++) begin
            wr(16'h0000, 8'hF0);
            prefix(); wr({4'hF, 12'h000}, c[7:0]);
            chk("R1 code sweep chip", int'(s_chip), int'(c == 8'h10));
            chk("R2 code sweep sector", int'(s_sector), int'(c == 8'h30));
            chk("R6 code sweep status", int'(rd_status), int'(c == 8'h10 || c == 8'h30));
        end

        // R6 mismatch at each step
        for (int k = 0; k < 5; k++) begin
            logic [15:0] aa [5];
            logic [7:0]  dd [5];
            aa = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA};
            dd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
            wr(16'h0000, 8'hF0);
            for (int j = 0; j < 5; j++)
                wr(aa[j], (j == k) ? (dd[j] ^ 8'h01) : dd[j]);
            wr(16'h0000, 8'h10);
            chk("R6 bad data step", int'(s_chip), 0);
            chk("R6 bad data mode", int'(rd_status), 0);
        end
        wr(16'h5554, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0000, 8'h10);
        chk("R6 bad address", int'(s_chip), 0);
        wr(16'h0000, 8'h70);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0000, 8'hF0);
        chk("R6 F0 mid sequence", int'(rd_status), 0);
        wr(16'h5555, 8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        wr(16'h0000, 8'h10);
        chk("R6 aborted by F0", int'(s_chip), 0);
        prefix(); wr(16'h0000, 8'h10);
        chk("R6 recovers", int'(s_chip), 1);

        // R3 address on fall, data on rise
        bus_wr(16'h5555, 16'h0000, 8'h00, 8'hAA, 1'b0);
        bus_wr(16'h2AAA, 16'h0000, 8'h00, 8'h55, 1'b0);
        bus_wr(16'h5555, 16'h0000, 8'h00, 8'h80, 1'b0);
        bus_wr(16'h5555, 16'h0000, 8'h00, 8'hAA, 1'b0);
        bus_wr(16'h2AAA, 16'h0000, 8'h00, 8'h55, 1'b0);
        bus_wr({4'h9, 12'h000}, {4'h2, 12'h000}, 8'h00, 8'h30, 1'b0);
        chk("R3 split sector", int'(s_sector), 1);
        chk("R3 sel from fall addr", int'(req_sector_sel), 9);
        bus_wr(16'h0000, 16'h5555, 8'hAA, 8'hAA, 1'b0);
        wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80); wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55); wr(16'h0000, 8'h10);
        chk("R3 rise addr unused", int'(s_chip), 0);
        bus_wr(16'h5555, 16'h5555, 8'hAA, 8'h00, 1'b0);
        wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80); wr(16'h5555, 8'hAA);
        wr(16'h2AAA, 8'h55); wr(16'h0000, 8'h10);
        chk("R3 fall data unused", int'(s_chip), 0);

        // R10 chip enable high
        prefix();
        bus_wr(16'h0000, 16'h0000, 8'h10, 8'h10, 1'b1);
        chk("R10 ce high ignored", int'(s_chip), 0);
        wr(16'h0000, 8'h10);
        chk("R10 position kept", int'(s_chip), 1);
        wr(16'h0000, 8'hF0);
        bus_wr(16'h0000, 16'h0000, 8'h70, 8'h70, 1'b1);
        chk("R10 70 ignored", int'(rd_status), 0);

        // R1 blocked while engine busy
        eng_busy = 1'b1;
        prefix(); wr(16'h0000, 8'h10);
        chk("R1 busy blocks", int'(s_chip), 0);

        // R7 suspend rules
        eng_busy = 1'b0;
        wr(16'h0000, 8'hB0);
        chk("R7 idle engine", int'(s_susp), 0);
        prefix(); wr(16'h0000, 8'h10);
        eng_busy = 1'b1;
        wr(16'h0000, 8'hB0);
        chk("R7 chip erase no suspend", int'(s_susp), 0);
        chk("R7 not suspended", int'(erase_suspended), 0);
        eng_busy = 1'b0;
        prefix(); wr({4'h5, 12'h000}, 8'h30);
        eng_busy = 1'b1;
        wr(16'h0000, 8'hF0);
        wr(16'h4321, 8'hB0);
        chk("R7 suspend req", int'(s_susp), 1);
        chk("R7 suspended", int'(erase_suspended), 1);
        chk("R7 status", int'(rd_status), 1);
        wr(16'h0000, 8'hB0);
        chk("R8 second B0", int'(s_susp), 0);

        // R8 suspended filter
        wr(16'h0000, 8'hF0);
        chk("R8 F0 accepted", int'(rd_status), 0);
        chk("R8 still suspended", int'(erase_suspended), 1);
        wr(16'h0000, 8'h70);
        chk("R8 70 accepted", int'(rd_status), 1);
        eng_busy = 1'b0;
        wr(16'h0000, 8'hF0);
        prefix(); wr(16'h0000, 8'h10);
        chk("R8 chip ignored", int'(s_chip), 0);
        prefix(); wr(16'h0000, 8'h30);
        chk("R8 sector ignored", int'(s_sector), 0);
        chk("R8 sel kept", int'(req_sector_sel), 5);
        chk("R8 mode kept", int'(rd_status), 0);
        eng_busy = 1'b1;

        // R9 resume
        wr(16'h7777, 8'hD0);
        chk("R9 resume req", int'(s_res), 1);
        chk("R9 cleared", int'(erase_suspended), 0);
        chk("R9 status", int'(rd_status), 1);
        wr(16'h0000, 8'hF0);
        wr(16'h0000, 8'hD0);
        chk("R9 no effect", int'(s_res), 0);
        chk("R9 mode kept", int'(rd_status), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule